// File: doc/BRIEF.md
# Branch History Recorder

This debug block keeps a rolling history of the most recent control transfers (taken branches, interrupts and exceptions) in a small circular store. A pointer register always names the slot that holds the newest record. Each record is 64 bits: the source address in the upper half and the destination address in the lower half. A three-bit control register holds a recording enable, a single-step-on-branches mode select and a trace-streaming enable.

A debug exception clears the recording enable by itself, so the history freezes as it stood when the exception was raised. Debug software can then read the slots and the pointer through a combinational read port. While streaming is enabled, every incoming event is also sent out as a one-cycle trace strobe carrying the same 64-bit record. This happens whether or not recording is enabled. The control register accepts writes only from privilege level 0 or from real-address mode.

Top module: `brh_top`

## Requirements
- R1: Reset (synchronous, active-low) clears the control register, sets the pointer to 0, zeroes every slot and holds the trace strobe low.
- R2: While control bit 0 is set, each event first advances the pointer by one modulo DEPTH and then stores the record {from in [63:32], to in [31:0]} in the slot at the new pointer. The pointer and slot contents are visible one cycle after the event.
- R3: After more than DEPTH recorded events, the pointer wraps past DEPTH-1 to 0 and the oldest slots are overwritten, while the other slots keep their records.
- R4: While control bit 0 is clear, events change neither the pointer nor any slot.
- R5: A debug exception clears control bit 0 on the next cycle and leaves bits 1 and 2 unchanged. An event in the same cycle is still recorded, and later events are not.
- R6: The single-step-on-branches output equals control bit 1.
- R7: A control write takes effect only when the privilege level input is 0 or the real-mode input is high. Any other write leaves the control register unchanged.
- R8: While control bit 2 is set, each event raises the trace strobe for exactly one cycle, on the cycle after the event, with the same 64-bit record as payload. Bit 0 has no influence on this.
- R9: If a permitted write and a debug exception occur in the same cycle, bits 2 and 1 take the written value and bit 0 ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Control-transfer event strobe |
| evt_from | input | AW | Source address of the event |
| evt_to | input | AW | Destination address of the event |
| dbg_exc | input | 1 | Debug exception strobe |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control write value: bit0 record, bit1 step mode, bit2 stream |
| cpl | input | 2 | Current privilege level |
| real_mode | input | 1 | Real-address mode indication |
| rd_idx | input | IW | Slot index for the read port |
| rd_data | output | 2*AW | Record held in slot rd_idx |
| tos | output | IW | Index of the newest record |
| ctrl | output | 3 | Current control register value |
| step_on_branch | output | 1 | Single-step-on-branches mode |
| trc_valid | output | 1 | Trace message strobe |
| trc_data | output | 2*AW | Trace message payload |

## Verification
On every cycle, assertions check the following:
- the pointer advances by exactly one on a recorded event and holds otherwise;
- an exception clears the enable on the next cycle;
- unprivileged writes leave the control register as it was;
- a write that coincides with an exception keeps the written upper bits;
- the trace strobe follows an enabled event with the matching payload and stays low otherwise.

Only the bench scenarios can show that records land in the right slot, that wrap-around overwrites only the oldest entries, and that the history is actually frozen after an exception. They do this by reading the slots back through the read port.

// File: rtl/brh_pkg.sv
// Package: shared control-bit positions for the branch history recorder.
// Assumes the control register is three bits wide.
package brh_pkg;
    localparam int CTRL_W   = 3;
    localparam int BIT_REC  = 0;  // recording enable
    localparam int BIT_STEP = 1;  // single-step on branches
    localparam int BIT_TRC  = 2;  // trace streaming enable
endpackage

// File: rtl/brh_ctrl.sv
// Module: control register with privilege-gated writes.
// A debug exception clears the recording enable after any same-cycle write.
// Assumes cpl == 0 or real_mode marks a privileged write.
module brh_ctrl
    import brh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [1:0]        cpl,
    input  logic              real_mode,
    input  logic              dbg_exc,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic priv_ok;

    // Purpose: decide whether the current write is privileged.
    always_comb priv_ok = (cpl == 2'd0) || real_mode;

    // Purpose: update the control register; the exception clear wins for bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_en && priv_ok) ctrl_q <= wr_data;
            if (dbg_exc)          ctrl_q[BIT_REC] <= 1'b0;
        end
    end

    p_exc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_exc |=> !ctrl_q[BIT_REC]);
    p_exc_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_exc && !wr_en) |=> ctrl_q[CTRL_W-1:1] == $past(ctrl_q[CTRL_W-1:1]));
    p_wr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpl != 2'd0 && !real_mode && !dbg_exc) |=> ctrl_q == $past(ctrl_q));
    p_wr_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (cpl == 2'd0 || real_mode) && dbg_exc)
            |=> ctrl_q == ($past(wr_data) & 3'b110));
endmodule

// File: rtl/brh_ring.sv
// Module: circular record store with a pointer to the newest slot.
// On a recorded event the pointer advances first, then the slot at the
// new pointer is written. Assumes DEPTH is a power of two.
module brh_ring #(
    parameter  int DEPTH = 16,
    parameter  int RW    = 64,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_en,
    input  logic [RW-1:0] rec_data,
    input  logic [IW-1:0] rd_idx,
    output logic [RW-1:0] rd_data,
    output logic [IW-1:0] tos
);
    logic [RW-1:0] slot [DEPTH];
    logic [IW-1:0] nxt;

    // Purpose: next pointer value, wrapping modulo DEPTH.
    always_comb nxt = (tos == IW'(DEPTH - 1)) ? '0 : tos + 1'b1;

    // Purpose: pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)      tos <= '0;
        else if (rec_en) tos <= nxt;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Purpose: one storage slot, written when the pointer lands on it.
        always_ff @(posedge clk) begin
            if (!rst_n)                          slot[g] <= '0;
            else if (rec_en && nxt == IW'(g))    slot[g] <= rec_data;
        end
    end

    // Purpose: combinational read of the selected slot.
    always_comb rd_data = slot[rd_idx];

    p_tos_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |=> tos == IW'(($past(tos) + 1) % DEPTH));
    p_tos_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> $stable(tos));
endmodule

// File: rtl/brh_trace.sv
// Module: trace message output stage. Emits a one-cycle strobe with the
// record on the cycle after an event, while streaming is enabled.
module brh_trace #(
    parameter int RW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic          stream_en,
    input  logic [RW-1:0] rec_data,
    output logic          trc_valid,
    output logic [RW-1:0] trc_data
);
    // Purpose: register the trace strobe and its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trc_valid <= 1'b0;
            trc_data  <= '0;
        end else begin
            trc_valid <= evt && stream_en;
            if (evt && stream_en) trc_data <= rec_data;
        end
    end

    p_trc_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && stream_en) |=> (trc_valid && trc_data == $past(rec_data)));
    p_trc_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt && stream_en) |=> !trc_valid);
endmodule

// File: rtl/brh_top.sv
// Module: branch history recorder top. Ties the control register, the
// circular store and the trace stage together. Record = {from, to}.
module brh_top
    import brh_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int AW    = 32,
    localparam int IW    = $clog2(DEPTH),
    localparam int RW    = 2 * AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [AW-1:0]     evt_from,
    input  logic [AW-1:0]     evt_to,
    input  logic              dbg_exc,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic [1:0]        cpl,
    input  logic              real_mode,
    input  logic [IW-1:0]     rd_idx,
    output logic [RW-1:0]     rd_data,
    output logic [IW-1:0]     tos,
    output logic [CTRL_W-1:0] ctrl,
    output logic              step_on_branch,
    output logic              trc_valid,
    output logic [RW-1:0]     trc_data
);
    logic [RW-1:0] rec;
    logic          rec_en;

    // Purpose: form the record and the store enable from the current control.
    always_comb begin
        rec    = {evt_from, evt_to};
        rec_en = evt_valid && ctrl[BIT_REC];
    end

    // Purpose: export the stepping mode.
    always_comb step_on_branch = ctrl[BIT_STEP];

    brh_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
        .cpl(cpl), .real_mode(real_mode), .dbg_exc(dbg_exc), .ctrl_q(ctrl)
    );

    brh_ring #(.DEPTH(DEPTH), .RW(RW)) u_ring (
        .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .rec_data(rec),
        .rd_idx(rd_idx), .rd_data(rd_data), .tos(tos)
    );

    brh_trace #(.RW(RW)) u_trace (
        .clk(clk), .rst_n(rst_n), .evt(evt_valid), .stream_en(ctrl[BIT_TRC]),
        .rec_data(rec), .trc_valid(trc_valid), .trc_data(trc_data)
    );

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (tos == '0 && ctrl == '0 && !trc_valid));
endmodule

// File: tb/sim_brh_top.sv
module sim_brh_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int AW = 32;
    localparam int IW = $clog2(DEPTH);

    logic clk = 0, rst_n = 0;
    logic evt_valid = 0, dbg_exc = 0, cfg_we = 0, real_mode = 0;
    logic [AW-1:0] evt_from = '0, evt_to = '0;
    logic [2:0] cfg_wdata = '0;
    logic [1:0] cpl = 2'd3;
    logic [IW-1:0] rd_idx = '0;
    logic [2*AW-1:0] rd_data, trc_data;
    logic [IW-1:0] tos;
    logic [2:0] ctrl;
    logic step_on_branch, trc_valid;

    int n_run = 0, n_fail = 0;
    logic [2*AW-1:0] m_slot [DEPTH];
    int m_tos = 0;
    logic [2:0] m_ctrl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brh_top #(.DEPTH(DEPTH), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_from(evt_from),
        .evt_to(evt_to), .dbg_exc(dbg_exc), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cpl(cpl), .real_mode(real_mode), .rd_idx(rd_idx), .rd_data(rd_data),
        .tos(tos), .ctrl(ctrl), .step_on_branch(step_on_branch),
        .trc_valid(trc_valid), .trc_data(trc_data)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every slot and the pointer against the model.
    task automatic chk_store(string req);
        chk(req, "tos", 64'(tos), 64'(m_tos));
        for (int i = 0; i < DEPTH; i++) begin
            rd_idx = IW'(i);
            #1;
            chk(req, $sformatf("slot %0d", i), rd_data, m_slot[i]);
        end
    endtask

    // One clock with a control write; model follows R7 / R9.
    task automatic wr_ctrl(logic [2:0] d, logic [1:0] lvl, logic rm, logic exc);
        @(negedge clk);
        cfg_we = 1; cfg_wdata = d; cpl = lvl; real_mode = rm; dbg_exc = exc;
        @(posedge clk);
        if (lvl == 0 || rm) m_ctrl = d;
        if (exc) m_ctrl[0] = 1'b0;
        @(negedge clk);
        cfg_we = 0; dbg_exc = 0; cpl = 2'd3; real_mode = 0;
    endtask

    // One clock with an event; model follows R2 / R5.
    task automatic evt(logic [31:0] f, logic [31:0] t, logic exc);
        @(negedge clk);
        evt_valid = 1; evt_from = f; evt_to = t; dbg_exc = exc;
        @(posedge clk);
        if (m_ctrl[0]) begin
            m_tos = (m_tos + 1) % DEPTH;
            m_slot[m_tos] = {f, t};
        end
        if (exc) m_ctrl[0] = 1'b0;
        @(negedge clk);
        evt_valid = 0; dbg_exc = 0;
    endtask

    task automatic t_reset;
        chk("R1", "ctrl", 64'(ctrl), 0);
        chk("R1", "trc_valid", 64'(trc_valid), 0);
        chk_store("R1");
    endtask

    task automatic t_priv;
        wr_ctrl(3'b010, 2'd3, 1'b0, 1'b0);
        chk("R7", "unpriv write ignored", 64'(ctrl), 0);
        wr_ctrl(3'b010, 2'd1, 1'b0, 1'b0);
        chk("R7", "level1 write ignored", 64'(ctrl), 0);
        wr_ctrl(3'b010, 2'd3, 1'b1, 1'b0);
        chk("R7", "real-mode write", 64'(ctrl), 64'(3'b010));
        chk("R6", "step mode on", 64'(step_on_branch), 1);
        wr_ctrl(3'b000, 2'd0, 1'b0, 1'b0);
        chk("R7", "level0 write", 64'(ctrl), 0);
        chk("R6", "step mode off", 64'(step_on_branch), 0);
    endtask

    task automatic t_disabled;
        evt(32'hAAAA_0001, 32'hBBBB_0001, 1'b0);
        chk("R4", "trace idle", 64'(trc_valid), 0);
        chk_store("R4");
    endtask

    task automatic t_record;
        wr_ctrl(3'b001, 2'd0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) evt(32'h1000_0000 + i, 32'h2000_0000 + i, 1'b0);
        chk_store("R2");
        chk("R2", "slot3 layout", m_slot[3], {32'h1000_0002, 32'h2000_0002});
    endtask

    task automatic t_wrap;
        for (int i = 0; i < DEPTH; i++) evt(32'h3000_0000 + i, 32'h4000_0000 + i, 1'b0);
        chk("R3", "tos wrapped", 64'(tos), 3);
        chk_store("R3");
    endtask

    task automatic t_exc;
        wr_ctrl(3'b011, 2'd0, 1'b0, 1'b0);
        evt(32'h5000_0000, 32'h6000_0000, 1'b1);
        chk("R5", "bit0 cleared, bit1 kept", 64'(ctrl), 64'(3'b010));
        chk_store("R5");
        evt(32'h5000_0001, 32'h6000_0001, 1'b0);
        chk_store("R5");
    endtask

    task automatic t_trace;
        wr_ctrl(3'b100, 2'd0, 1'b0, 1'b0);
        evt(32'h7000_00AA, 32'h8000_00BB, 1'b0);
        chk("R8", "strobe", 64'(trc_valid), 1);
        chk("R8", "payload", trc_data, {32'h7000_00AA, 32'h8000_00BB});
        chk_store("R8");
        @(negedge clk);
        chk("R8", "strobe one cycle", 64'(trc_valid), 0);
    endtask

    task automatic t_wr_exc;
        wr_ctrl(3'b111, 2'd0, 1'b0, 1'b1);
        chk("R9", "write with exception", 64'(ctrl), 64'(3'b110));
        chk("R6", "step mode", 64'(step_on_branch), 1);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_slot[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_priv;
        t_disabled;
        t_record;
        t_wrap;
        t_exc;
        t_trace;
        t_wr_exc;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule